// File: doc/BRIEF.md
# Coefficient Pair Byte Packer

This block turns a run of 12-bit polynomial coefficients into a byte stream. Each polynomial has 256 coefficients. The block takes them two at a time, an even coefficient and the odd one after it, and emits three bytes per pair. A run covers 2K polynomials. The first K come from a public coefficient RAM and the remaining K come from a secret coefficient RAM. K is supplied at start and may be 2, 3 or 4.

Both RAMs have a registered read port. The data for an address appears in the cycle after the read enable. It then holds until the next enabled read of that RAM. The packer issues the even read of a pair before the pair's first byte is due. It issues the odd read when that first byte is accepted. A RAM therefore never has to serve two reads for the same byte slot.

The bytes leave on a valid/ready handshake. A stalled consumer freezes both the read schedule and the byte on offer. After the last byte of the final polynomial is accepted, a single-cycle done pulse marks the end of the run.

Top module: `coef_pair_packer`

## Requirements
- R1: The first byte of every pair equals bits 7:0 of the even coefficient.
- R2: The second byte of every pair is the odd coefficient's bits 3:0 in its upper nibble, above the even coefficient's bits 11:8 in its lower nibble.
- R3: The third byte of every pair equals bits 11:4 of the odd coefficient.
- R4: Pair p of a polynomial uses coefficient indices 2p and 2p+1. Pairs run from 0 to 127 and polynomials from 0 to 2K-1, so one run emits exactly 768·K bytes.
- R5: Polynomial n < K is read from the public RAM at address n·256 + index. Polynomial n ≥ K is read from the secret RAM at address (n−K)·256 + index. The read enable of the other RAM stays low in that cycle.
- R6: Every coefficient is read exactly once (512·K reads per run), in index order, with at most one read enable high per cycle. The first byte is offered two cycles after the clock edge that accepts start.
- R7: While a byte is offered and not accepted, no read is issued, and in the next cycle the same byte is still offered.
- R8: done_o is high for exactly one cycle, the cycle after the edge that accepts the last byte. byte_valid_o is low in that cycle and after it.
- R9: start_i is ignored while a run is in progress, including any change on k_i at that time.
- R10: Out of reset, byte_valid_o, done_o and both read enables are low until start_i is sampled.
- R11: K is sampled at start and sets the number of polynomials and the split point between the two RAMs for that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a run when the block is idle |
| k_i | input | 3 | Polynomials per half, 2 to 4, sampled at start |
| pub_rd_en_o | output | 1 | Read enable of the public coefficient RAM |
| pub_rd_addr_o | output | 10 | Read address of the public RAM |
| pub_rd_data_i | input | 12 | Public RAM read data, one cycle after enable |
| sec_rd_en_o | output | 1 | Read enable of the secret coefficient RAM |
| sec_rd_addr_o | output | 10 | Read address of the secret RAM |
| sec_rd_data_i | input | 12 | Secret RAM read data, one cycle after enable |
| byte_valid_o | output | 1 | A packed byte is offered |
| byte_data_o | output | 8 | The packed byte |
| byte_ready_i | input | 1 | Consumer accepts the offered byte |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
Results fall due at fixed offsets from events at the ports:
- A read enable appears in the first cycle after start is accepted.
- The first byte is offered one cycle after that read enable.
- Each RAM word is visible in the cycle after its enable.
- The done pulse comes in the cycle after the final accepted byte.

The bench drives inputs and samples every output at the falling edge. Each expected value is tied to the count of edges since the event that causes it: the Nth accepted byte is compared with a value computed from the run position N, the Nth read against index order, and a stall against the byte seen one edge earlier. Runs cover every legal K with a consumer that is always ready, one with random stalls and one with periodic stalls, plus a mid-run start request that has to be ignored.

// File: rtl/cpbp_pkg.sv
package cpbp_pkg;

  localparam int COEF_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_LANE0,
    ST_LANE1,
    ST_LANE2
  } pk_state_e;

  // Byte slot of a coefficient pair: 0 -> even low, 1 -> nibble splice, 2 -> odd high
  function automatic logic [7:0] pack_lane(input logic [1:0] lane,
                                           input logic [COEF_W-1:0] ev,
                                           input logic [COEF_W-1:0] od);
    logic [7:0] b;
    case (lane)
      2'd0:    b = ev[7:0];
      2'd1:    b = {od[3:0], ev[11:8]};
      default: b = od[11:4];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cpbp_cursor.sv
module cpbp_cursor #(
  parameter int POLY_W = 3,
  parameter int PAIR_W = 7,
  parameter int NPAIR  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [POLY_W-1:0] last_poly,
  output logic [POLY_W-1:0] cur_poly,
  output logic [PAIR_W-1:0] cur_pair,
  output logic [POLY_W-1:0] nxt_poly,
  output logic [PAIR_W-1:0] nxt_pair,
  output logic              is_last
);

  logic pair_wrap;

  assign pair_wrap = (cur_pair == PAIR_W'(NPAIR - 1));
  assign nxt_pair  = pair_wrap ? '0 : cur_pair + 1'b1;
  assign nxt_poly  = pair_wrap ? cur_poly + 1'b1 : cur_poly;
  assign is_last   = pair_wrap && (cur_poly == last_poly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_poly <= '0;
      cur_pair <= '0;
    end else if (clear) begin
      cur_poly <= '0;
      cur_pair <= '0;
    end else if (step) begin
      cur_poly <= nxt_poly;
      cur_pair <= nxt_pair;
    end
  end

endmodule

// File: rtl/cpbp_locate.sv
module cpbp_locate #(
  parameter int POLY_W = 3,
  parameter int PAIR_W = 7,
  parameter int KW     = 3,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic [POLY_W-1:0] poly,
  input  logic [PAIR_W-1:0] pair,
  input  logic              odd,
  input  logic [KW-1:0]     k,
  output logic              secret,
  output logic [ADDR_W-1:0] addr
);

  localparam int CW = (POLY_W > KW) ? POLY_W : KW;

  logic [CW-1:0] poly_w, k_w, rel;

  assign poly_w = CW'(poly);
  assign k_w    = CW'(k);
  assign secret = (poly_w >= k_w);
  assign rel    = secret ? (poly_w - k_w) : poly_w;
  assign addr   = (ADDR_W'(rel) << IDX_W) | ADDR_W'({pair, odd});

endmodule

// File: rtl/cpbp_lane.sv
module cpbp_lane
  import cpbp_pkg::*;
(
  input  logic [1:0]        lane,
  input  logic [COEF_W-1:0] ev,
  input  logic [COEF_W-1:0] od,
  output logic [7:0]        byte_o
);

  assign byte_o = pack_lane(lane, ev, od);

endmodule

// File: rtl/coef_pair_packer.sv
module coef_pair_packer
  import cpbp_pkg::*;
#(
  parameter int N_COEF = 256,
  parameter int KMAX   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [$clog2(KMAX+1)-1:0]        k_i,
  output logic                             pub_rd_en_o,
  output logic [$clog2(KMAX*N_COEF)-1:0]   pub_rd_addr_o,
  input  logic [11:0]                      pub_rd_data_i,
  output logic                             sec_rd_en_o,
  output logic [$clog2(KMAX*N_COEF)-1:0]   sec_rd_addr_o,
  input  logic [11:0]                      sec_rd_data_i,
  output logic                             byte_valid_o,
  output logic [7:0]                       byte_data_o,
  input  logic                             byte_ready_i,
  output logic                             done_o
);

  localparam int NPAIR  = N_COEF / 2;
  localparam int PAIR_W = $clog2(NPAIR);
  localparam int IDX_W  = $clog2(N_COEF);
  localparam int POLY_W = $clog2(2 * KMAX);
  localparam int KW     = $clog2(KMAX + 1);
  localparam int ADDR_W = $clog2(KMAX * N_COEF);

  pk_state_e         state_q, state_d;
  logic [KW-1:0]     k_q;
  logic [COEF_W-1:0] ev_q;
  logic              src_q;
  logic              done_q;

  // Named internal events
  logic fire, rd_go, launch, ev_latch, pair_step, stream_end;
  logic [POLY_W-1:0] cur_poly, nxt_poly, loc_poly, last_poly;
  logic [PAIR_W-1:0] cur_pair, nxt_pair, loc_pair;
  logic              is_last, loc_odd, loc_secret;
  logic [ADDR_W-1:0] loc_addr;
  logic [COEF_W-1:0] cur_coef, ev_src;
  logic [1:0]        lane;

  assign byte_valid_o = (state_q == ST_LANE0) || (state_q == ST_LANE1) || (state_q == ST_LANE2);
  assign fire         = byte_valid_o && byte_ready_i;
  assign launch       = (state_q == ST_IDLE) && start_i;
  assign ev_latch     = (state_q == ST_LANE0) && fire;
  assign pair_step    = (state_q == ST_LANE2) && fire && !is_last;
  assign stream_end   = (state_q == ST_LANE2) && fire && is_last;
  assign rd_go        = (state_q == ST_PRIME) || ev_latch || pair_step;
  assign last_poly    = POLY_W'({k_q, 1'b0} - (KW+1)'(1));

  cpbp_cursor #(
    .POLY_W (POLY_W),
    .PAIR_W (PAIR_W),
    .NPAIR  (NPAIR)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch),
    .step      (pair_step),
    .last_poly (last_poly),
    .cur_poly  (cur_poly),
    .cur_pair  (cur_pair),
    .nxt_poly  (nxt_poly),
    .nxt_pair  (nxt_pair),
    .is_last   (is_last)
  );

  // Lane 2 launches the even read of the following pair; lane 0 the odd read.
  assign loc_poly = (state_q == ST_LANE2) ? nxt_poly : cur_poly;
  assign loc_pair = (state_q == ST_LANE2) ? nxt_pair : cur_pair;
  assign loc_odd  = (state_q == ST_LANE0);

  cpbp_locate #(
    .POLY_W (POLY_W),
    .PAIR_W (PAIR_W),
    .KW     (KW),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_locate (
    .poly   (loc_poly),
    .pair   (loc_pair),
    .odd    (loc_odd),
    .k      (k_q),
    .secret (loc_secret),
    .addr   (loc_addr)
  );

  assign pub_rd_en_o   = rd_go && !loc_secret;
  assign sec_rd_en_o   = rd_go && loc_secret;
  assign pub_rd_addr_o = loc_addr;
  assign sec_rd_addr_o = loc_addr;

  assign cur_coef = src_q ? sec_rd_data_i : pub_rd_data_i;
  assign ev_src   = (state_q == ST_LANE0) ? cur_coef : ev_q;
  assign lane     = (state_q == ST_LANE1) ? 2'd1 : (state_q == ST_LANE2) ? 2'd2 : 2'd0;

  cpbp_lane u_lane (
    .lane   (lane),
    .ev     (ev_src),
    .od     (cur_coef),
    .byte_o (byte_data_o)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_PRIME;
      ST_PRIME: state_d = ST_LANE0;
      ST_LANE0: if (fire) state_d = ST_LANE1;
      ST_LANE1: if (fire) state_d = ST_LANE2;
      ST_LANE2: if (fire) state_d = is_last ? ST_IDLE : ST_LANE0;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= KW'(2);
      ev_q    <= '0;
      src_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= stream_end;
      if (launch)   k_q   <= k_i;
      if (ev_latch) ev_q  <= cur_coef;
      if (rd_go)    src_q <= loc_secret;
    end
  end

  assign done_o = done_q;

  assert_stall_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |-> !(pub_rd_en_o || sec_rd_en_o));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(fire) && !byte_valid_o));

  assert_read_before_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid_o) |-> $past(pub_rd_en_o || sec_rd_en_o));

  assert_pub_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pub_rd_en_o |-> (32'(pub_rd_addr_o) < 32'(k_q) * N_COEF));

  assert_sec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rd_en_o |-> (32'(sec_rd_addr_o) < 32'(k_q) * N_COEF));

endmodule

// File: tb/coef_pair_packer_bench.sv
module coef_pair_packer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] k_i = 3'd2;
  logic       pub_rd_en_o, sec_rd_en_o;
  logic [9:0] pub_rd_addr_o, sec_rd_addr_o;
  logic [11:0] pub_q = '0, sec_q = '0;
  logic       byte_valid_o;
  logic [7:0] byte_data_o;
  logic       byte_ready_i = 1'b0;
  logic       done_o;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  coef_pair_packer u_coef_pair_packer (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .k_i           (k_i),
    .pub_rd_en_o   (pub_rd_en_o),
    .pub_rd_addr_o (pub_rd_addr_o),
    .pub_rd_data_i (pub_q),
    .sec_rd_en_o   (sec_rd_en_o),
    .sec_rd_addr_o (sec_rd_addr_o),
    .sec_rd_data_i (sec_q),
    .byte_valid_o  (byte_valid_o),
    .byte_data_o   (byte_data_o),
    .byte_ready_i  (byte_ready_i),
    .done_o        (done_o)
  );

  function automatic int ram_val(input int src, input int a);
    return (a * 173 + src * 2048 + 91) % 4096;
  endfunction

  // Registered-read RAMs that hold their output between reads
  always @(posedge clk) begin
    if (pub_rd_en_o) pub_q <= 12'(ram_val(0, int'(pub_rd_addr_o)));
    if (sec_rd_en_o) sec_q <= 12'(ram_val(1, int'(sec_rd_addr_o)));
  end

  function automatic int coef_of(input int k, input int poly, input int idx);
    if (poly < k) return ram_val(0, poly * 256 + idx);
    return ram_val(1, (poly - k) * 256 + idx);
  endfunction

  function automatic int exp_byte(input int k, input int b);
    int poly, r, pair, lane, ev, od;
    poly = b / 384;
    r    = b % 384;
    pair = r / 3;
    lane = r % 3;
    ev   = coef_of(k, poly, 2 * pair);
    od   = coef_of(k, poly, 2 * pair + 1);
    if (lane == 0) return ev % 256;
    if (lane == 1) return (od % 16) * 16 + (ev / 256);
    return od / 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int k, input int stall_sel, input bit poke);
    int bytes = 0;
    int reads = 0;
    int first_it = -1;
    bit prev_stall = 0;
    logic [7:0] prev_data = '0;
    bit exp_done = 0;
    bit seen_done = 0;
    bit poked = 0;
    @(negedge clk);
    start_i = 1'b1;
    k_i = 3'(k);
    for (int it = 1; it < 30000 && !seen_done; it++) begin
      @(negedge clk);
      start_i = 1'b0;
      k_i = 3'(k);
      if (poke && bytes == 500 && !poked) begin
        start_i = 1'b1;
        k_i = 3'd2;
        poked = 1;
      end
      case (stall_sel)
        0: byte_ready_i = 1'b1;
        1: byte_ready_i = lfsr[0];
        default: byte_ready_i = (it % 4 != 0);
      endcase
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      // R8 done pulse timing
      if (exp_done) begin
        chk(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
        chk(byte_valid_o == 1'b0, "R8 valid low at done", int'(byte_valid_o), 0);
        seen_done = 1;
      end else if (done_o) begin
        chk(1'b0, "R8 early done", 1, 0);
      end
      exp_done = 0;
      // R7 stall holds the byte
      if (prev_stall)
        chk(byte_valid_o && byte_data_o == prev_data, "R7 stall hold",
            int'(byte_data_o), int'(prev_data));
      // R6 latency of first byte
      if (byte_valid_o && first_it < 0) begin
        first_it = it;
        chk(it == 2, "R6 first byte latency", it, 2);
      end
      // R5 / R6 read order and source
      if (pub_rd_en_o && sec_rd_en_o) chk(1'b0, "R6 two reads", 2, 1);
      if (pub_rd_en_o || sec_rd_en_o) begin
        int poly, idx, ea, act_a;
        bit es;
        poly = reads / 256;
        idx  = reads % 256;
        es   = (poly >= k);
        ea   = (es ? poly - k : poly) * 256 + idx;
        act_a = sec_rd_en_o ? int'(sec_rd_addr_o) : int'(pub_rd_addr_o);
        chk(sec_rd_en_o == es, "R5 source", int'(sec_rd_en_o), int'(es));
        chk(act_a == ea, "R5 address", act_a, ea);
        reads++;
      end
      if (byte_valid_o && !byte_ready_i) begin
        chk(!(pub_rd_en_o || sec_rd_en_o), "R7 no read in stall", 1, 0);
        prev_stall = 1;
        prev_data = byte_data_o;
      end else begin
        prev_stall = 0;
      end
      if (byte_valid_o && byte_ready_i) begin
        int e, ln;
        e  = exp_byte(k, bytes);
        ln = (bytes % 384) % 3;
        if (ln == 0)      chk(int'(byte_data_o) == e, "R1 even low byte", int'(byte_data_o), e);
        else if (ln == 1) chk(int'(byte_data_o) == e, "R2 nibble splice", int'(byte_data_o), e);
        else              chk(int'(byte_data_o) == e, "R3 odd high byte", int'(byte_data_o), e);
        if (bytes == 768 * k - 1) exp_done = 1;
        bytes++;
      end
    end
    chk(seen_done, "R8 done seen", int'(seen_done), 1);
    if (poke) chk(bytes == 768 * k, "R9 start ignored, length kept", bytes, 768 * k);
    else      chk(bytes == 768 * k, "R4 R11 stream length", bytes, 768 * k);
    chk(reads == 512 * k, "R6 read count", reads, 512 * k);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      byte_ready_i = 1'b1;
      #1;
      chk(!byte_valid_o && !done_o && !pub_rd_en_o && !sec_rd_en_o, "R8 quiet after end",
          int'(byte_valid_o), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog R4: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      #1;
      chk(!byte_valid_o && !done_o && !pub_rd_en_o && !sec_rd_en_o, "R10 reset idle",
          int'(byte_valid_o) + int'(done_o), 0);
    end
    run_case(2, 0, 1'b0);
    run_case(3, 1, 1'b1);
    run_case(4, 2, 1'b0);
    run_case(2, 1, 1'b0);
    run_case(4, 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule